// File: doc/BRIEF.md
# Prioritized interrupt level encoder

This block sits between a board's interrupt sources and a processor that takes one 4-bit interrupt level. Thirteen level-sensitive request lines are placed into a 16-bit monitor word at fixed, irregular bit positions. Software gates that word with a 16-bit mask. Among the requests that are both pending and unmasked, the block picks the one with the lowest priority number. It drives that number inverted on a registered 4-bit output, so an output of 0 means no interrupt is requested.

A small 16-bit register window sits beside the encoder. It holds the mask, a general-purpose output port and a constant version word. Writing it to a power-off control location with bit 0 set produces a one-cycle shutdown request.

Top module: `irq_level_encoder`

## Requirements
- R1: A source takes part in arbitration only when its request line is high and its mask bit is set. The mask bit positions, by request index 0..12, are 9, 8, 14, 13, 12, 11, 10, 6, 5, 4, 7, 0 and 15. Mask bits 1, 2 and 3 have no effect.
- R2: Among the participating sources, the smallest priority value wins. The priorities, by request index 0..12, are 1, 2, 9, 10, 3, 0, 4, 5, 6, 7, 8, 11 and 12.
- R3: `irl_o` equals the winning priority XOR 15. With no participating source the selected value is 15, so `irl_o` is 0.
- R4: `irl_o` is registered. After each rising edge it reflects the request lines sampled at that edge and the mask as it stands after that edge, including a mask write done on the same edge.
- R5: Offset 0x00 is the mask register. A write stores `wdata_i`, and a read returns the stored value.
- R6: Offset 0x36 is the output port. A write stores `wdata_i`, which then appears on `gpo_o` from the next cycle. A read returns the stored value.
- R7: Offset 0x32 reads 0x0010. Writes to it change nothing.
- R8: Offset 0x30 reads 0. A write there with bit 0 set raises `shutdown_o` for the one following cycle. A write with bit 0 clear raises no pulse.
- R9: Any other offset reads 0, and writes to it change neither the mask nor the output port.
- R10: A synchronous reset clears the mask, the output port, `irl_o` and `shutdown_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 13 | Level-sensitive interrupt request lines |
| wr_i | input | 1 | Register write strobe, one write per cycle |
| addr_i | input | 6 | Byte offset into the register window |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| irl_o | output | 4 | Inverted winning priority, 0 when idle |
| shutdown_o | output | 1 | One-cycle shutdown request |
| gpo_o | output | 16 | General-purpose output port |

## Verification
Each source is first raised alone under a full mask. This separates the thirteen priorities and shows that bit position does not decide the order. Next, all sources are raised while a single mask bit walks across the word, which proves that each mask bit gates exactly its own source and that bits 1 to 3 gate nothing. Pairs and the all-on pattern then show that the lowest priority number beats every higher one. Mask writes done together with request changes separate the same-edge update from a stale mask. Writes to the version, power-off and unmapped offsets are each followed by readback and port checks.

// File: rtl/irq_level_encoder.sv
module irq_level_encoder #(
  parameter int          ADDR_W  = 6,
  parameter logic [15:0] VERSION = 16'h0010
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [12:0]       req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic [3:0]        irl_o,
  output logic              shutdown_o,
  output logic [15:0]       gpo_o
);
  localparam int NSRC = 13;
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(6'h00);
  localparam logic [ADDR_W-1:0] A_POFF = ADDR_W'(6'h30);
  localparam logic [ADDR_W-1:0] A_VER  = ADDR_W'(6'h32);
  localparam logic [ADDR_W-1:0] A_GPO  = ADDR_W'(6'h36);

  function automatic logic [3:0] src_prio(input int i);
    case (i)
      0: return 4'd1;   1: return 4'd2;   2: return 4'd9;   3: return 4'd10;
      4: return 4'd3;   5: return 4'd0;   6: return 4'd4;   7: return 4'd5;
      8: return 4'd6;   9: return 4'd7;   10: return 4'd8;  11: return 4'd11;
      default: return 4'd12;
    endcase
  endfunction

  function automatic logic [3:0] src_bit(input int i);
    case (i)
      0: return 4'd9;   1: return 4'd8;   2: return 4'd14;  3: return 4'd13;
      4: return 4'd12;  5: return 4'd11;  6: return 4'd10;  7: return 4'd6;
      8: return 4'd5;   9: return 4'd4;   10: return 4'd7;  11: return 4'd0;
      default: return 4'd15;
    endcase
  endfunction

  logic [15:0] mask_q, gpo_q, mask_nxt, monitor;
  logic [3:0]  sel, irl_q;
  logic        sd_q;

  wire wr_mask = wr_i && addr_i == A_MASK;
  wire wr_gpo  = wr_i && addr_i == A_GPO;
  wire wr_poff = wr_i && addr_i == A_POFF;

  assign mask_nxt = wr_mask ? wdata_i : mask_q;

  always_comb begin
    monitor = '0;
    for (int i = 0; i < NSRC; i++) monitor[src_bit(i)] = req_i[i];
  end

  always_comb begin
    sel = 4'hF;
    for (int i = 0; i < NSRC; i++)
      if ((monitor & mask_nxt) >> src_bit(i) & 16'd1 ? src_prio(i) < sel : 1'b0)
        sel = src_prio(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      gpo_q  <= '0;
      irl_q  <= '0;
      sd_q   <= 1'b0;
    end else begin
      mask_q <= mask_nxt;
      if (wr_gpo) gpo_q <= wdata_i;
      irl_q  <= sel ^ 4'hF;
      sd_q   <= wr_poff && wdata_i[0];
    end
  end

  always_comb begin
    case (addr_i)
      A_MASK:  rdata_o = mask_q;
      A_GPO:   rdata_o = gpo_q;
      A_VER:   rdata_o = VERSION;
      default: rdata_o = '0;
    endcase
  end

  assign irl_o      = irl_q;
  assign shutdown_o = sd_q;
  assign gpo_o      = gpo_q;
endmodule

module irq_level_encoder_chk (
  input logic        clk,
  input logic        rst,
  input logic [12:0] req_i,
  input logic        wr_i,
  input logic [5:0]  addr_i,
  input logic [15:0] wdata_i,
  input logic [15:0] rdata_o,
  input logic [3:0]  irl_o,
  input logic        shutdown_o,
  input logic [15:0] gpo_o
);
  // R10
  reset_clear_chk: assert property (@(posedge clk) rst |=> (irl_o == 4'd0 && gpo_o == 16'd0 && !shutdown_o));

  // R8
  shutdown_src_chk: assert property (@(posedge clk) disable iff (rst)
    shutdown_o |-> $past(wr_i && addr_i == 6'h30 && wdata_i[0]));

  // R7
  version_read_chk: assert property (@(posedge clk) disable iff (rst)
    addr_i == 6'h32 |-> rdata_o == 16'h0010);

  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_i != 6'h00 && addr_i != 6'h32 && addr_i != 6'h36) |-> rdata_o == 16'h0000);

  // R6
  gpo_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_i && addr_i == 6'h36)) |-> $stable(gpo_o));

  // R2
  top_prio_chk: assert property (@(posedge clk) disable iff (rst)
    irl_o == 4'd15 |-> $past(req_i[5]));
endmodule

bind irq_level_encoder irq_level_encoder_chk u_chk (.*);

// File: tb/sim_irq_level_encoder.sv
`timescale 1ns/1ps
module sim_irq_level_encoder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [12:0] req = '0;
  logic wr = 1'b0;
  logic [5:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, gpo;
  logic [3:0] irl;
  logic sd;

  int total = 0, bad = 0;
  bit done = 0;
  int prio_t [13] = '{1, 2, 9, 10, 3, 0, 4, 5, 6, 7, 8, 11, 12};
  int bit_t  [13] = '{9, 8, 14, 13, 12, 11, 10, 6, 5, 4, 7, 0, 15};
  logic [15:0] m_mask = '0, m_gpo = '0;
  int m_irl = 0;
  bit m_sd = 0;

  always #2.5 clk = ~clk;

  irq_level_encoder u0 (.clk(clk), .rst(rst), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irl_o(irl), .shutdown_o(sd), .gpo_o(gpo));

  function automatic int model_irl(logic [12:0] r, logic [15:0] m);
    int best = 15;
    for (int i = 0; i < 13; i++)
      if (r[i] && m[bit_t[i]] && prio_t[i] < best) best = prio_t[i];
    return best ^ 15;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(logic r_rst, logic [12:0] r, logic w, logic [5:0] a, logic [15:0] d);
    int exp_rd;
    rst = r_rst; req = r; wr = w; addr = a; wdata = d;
    #1;
    if (!r_rst) begin
      exp_rd = (a == 6'h00) ? m_mask : (a == 6'h36) ? m_gpo : (a == 6'h32) ? 16'h0010 : 0;
      if (a == 6'h00)      check(rdata == exp_rd, "R5 mask read", rdata, exp_rd);
      else if (a == 6'h36) check(rdata == exp_rd, "R6 port read", rdata, exp_rd);
      else if (a == 6'h32) check(rdata == exp_rd, "R7 version read", rdata, exp_rd);
      else if (a == 6'h30) check(rdata == exp_rd, "R8 poweroff read", rdata, exp_rd);
      else                 check(rdata == exp_rd, "R9 unmapped read", rdata, exp_rd);
    end
    @(posedge clk);
    if (r_rst) begin
      m_mask = '0; m_gpo = '0; m_irl = 0; m_sd = 0;
    end else begin
      if (w && a == 6'h00) m_mask = d;
      if (w && a == 6'h36) m_gpo = d;
      m_sd = w && a == 6'h30 && d[0];
      m_irl = model_irl(r, m_mask);
    end
    #1;
    if (r_rst) begin
      check(irl == 0 && gpo == 0 && !sd, "R10 reset state", {irl, gpo, 3'b0, sd}, 0);
    end else begin
      check(irl == m_irl, "R1 R2 R3 R4 level", irl, m_irl);
      check(gpo == m_gpo, "R6 R9 port", gpo, m_gpo);
      check(sd == m_sd, "R8 shutdown", sd, m_sd);
    end
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(1, '0, 0, 0, 0);
    cyc(1, '1, 1, 6'h00, 16'hFFFF);
    cyc(0, '1, 0, 6'h00, 0);                 // R1: mask zero, all requests
    cyc(0, '0, 1, 6'h00, 16'hFFFF);          // R4: mask write with idle requests
    for (int i = 0; i < 13; i++) cyc(0, 13'(1) << i, 0, 6'h00, 0); // R2 singles
    cyc(0, '0, 0, 6'h00, 0);
    for (int b = 0; b < 16; b++) cyc(0, '1, 1, 6'h00, 16'(1) << b); // R1 walking mask
    cyc(0, '1, 1, 6'h00, 16'hFFFF);          // R2: all on -> top priority
    cyc(0, '1, 1, 6'h00, 16'hF7FF);          // drop top source's mask
    cyc(0, 13'h0C03, 0, 6'h00, 0);
    cyc(0, 13'h1804, 0, 6'h00, 0);
    cyc(0, 13'h1000, 0, 6'h00, 0);
    cyc(0, 13'h0021, 1, 6'h00, 16'h0800);    // R4: same-edge mask write
    cyc(0, 13'h0021, 0, 6'h00, 0);
    cyc(0, 13'h0021, 1, 6'h36, 16'hA5C3);    // R6
    cyc(0, 13'h0021, 0, 6'h36, 0);
    cyc(0, 13'h0021, 1, 6'h32, 16'h1234);    // R7 write ignored
    cyc(0, 13'h0021, 0, 6'h32, 0);
    cyc(0, 13'h0021, 1, 6'h30, 16'h0002);    // R8 bit0 clear
    cyc(0, 13'h0021, 1, 6'h30, 16'h0001);    // R8 pulse
    cyc(0, 13'h0021, 0, 6'h30, 0);
    cyc(0, 13'h0021, 1, 6'h02, 16'hFFFF);    // R9 writes ignored
    cyc(0, 13'h0021, 1, 6'h3E, 16'h0000);
    cyc(0, 13'h0021, 1, 6'h01, 16'h0000);
    cyc(0, 13'h0021, 0, 6'h00, 0);
    cyc(0, 13'h0021, 0, 6'h36, 0);
    cyc(0, 13'h0021, 0, 6'h31, 0);
    cyc(1, 13'h0021, 0, 6'h00, 0);           // R10
    cyc(0, 13'h0021, 0, 6'h00, 0);
    cyc(0, 13'h0021, 0, 6'h36, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule